// File: doc/BRIEF.md
# Chamber Roll-Call Vote Tally with Result Hold

This block counts an electronic roll-call vote for a chamber of 200 seats. Every seat feeds two bits into the block: one that says whether the member is in attendance and one that carries a YES or NO choice. Only members in attendance are counted. The block keeps two counts: how many members are present, and how many present members chose YES. From these counts it lights exactly one of three outcome lamps, YES, TIE or NO. It also shows the number of members present as a three-digit decimal value on 7-segment digits.

The presiding officer has one switch that freezes the vote. When the switch turns on, the counts and the outcome are captured, and later switch movement by members cannot disturb them. When the switch turns off again, the display follows the live tally once more. Internally the block runs through three modes. IDLE follows reset. VOTING tracks the seats. RESULT holds the captured values.

Top module: `vote_tally`

## Requirements
- R1: While reset is asserted, and in IDLE, the held present and YES counts are zero. This means TIE is lit, the hundreds digit is blank, and the tens and ones digits show 0. IDLE loads no seat data.
- R2: The displayed number equals the count of presence bits at 1. It is shown in decimal on three digits. Segment bit 0 is a and bit 6 is g, active high. The digit patterns are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).
- R3: The vote bit of a seat whose presence bit is 0 has no effect on the count or the outcome.
- R4: With Y as the YES count among present members and P as the present count, YES is lit when 2Y > P. NO is lit when 2Y < P. TIE is lit when 2Y = P, which includes P = 0.
- R5: Exactly one of the three outcome lamps is lit in every cycle.
- R6: The hundreds digit is blank (all segments 0) when the present count is below 100. The tens and ones digits are never blanked. A full chamber shows 200.
- R7: If the officer switch is 1 at a rising edge in VOTING, the seat values at that edge are captured. While the switch stays 1, lamps and digits stay constant whatever the seats do.
- R8: The switch returning to 0 in RESULT moves the block to VOTING at the next edge, with the held values still shown. The live tally appears from the edge after that.
- R9: If the switch is 1 when IDLE is entered from reset, the block stays in IDLE with cleared outputs until the switch reads 0.
- R10: In VOTING, a change on the seat inputs reaches the lamps and digits after exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presence | input | 200 | Attendance bit per seat, 1 = present |
| vote | input | 200 | Choice bit per seat, 1 = YES, 0 = NO |
| chair_sw | input | 1 | Officer hold switch, 1 = freeze result |
| lamp_yes | output | 1 | YES outcome lamp |
| lamp_tie | output | 1 | TIE outcome lamp |
| lamp_no | output | 1 | NO outcome lamp |
| seg_hund | output | 7 | Hundreds digit segments g..a |
| seg_tens | output | 7 | Tens digit segments g..a |
| seg_ones | output | 7 | Ones digit segments g..a |

## Verification
In VOTING, the lamps and digits reflect the seat inputs one rising edge after those inputs are applied. Two other transitions take two edges before live data shows: leaving reset, and turning the hold switch off. The first edge only changes mode. The bench drives every input on a falling edge and samples on a later falling edge. It waits one edge for tally changes and two edges after reset release or switch release, and it samples the intermediate edge where a requirement defines it. Hold checks sample several cycles after seat changes, to show that the frozen values persist.

// File: rtl/vote_pkg.sv
package vote_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_VOTING = 2'd1,
    MODE_RESULT = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    OUT_TIE = 2'd0,
    OUT_YES = 2'd1,
    OUT_NO  = 2'd2
  } outcome_e;

  localparam int DIGITS = 3;
  localparam int BIN_W  = 10;

  // shift-add-3 binary to packed BCD
  function automatic logic [4*DIGITS-1:0] to_bcd(input logic [BIN_W-1:0] bin);
    logic [4*DIGITS-1:0] bcd;
    bcd = '0;
    for (int i = BIN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (bcd[4*d +: 4] >= 4'd5) bcd[4*d +: 4] = bcd[4*d +: 4] + 4'd3;
      end
      bcd = {bcd[4*DIGITS-2:0], bin[i]};
    end
    return bcd;
  endfunction

  // bit0 = a ... bit6 = g, active high
  function automatic logic [6:0] seg_of(input logic [3:0] d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  // YES wins when twice the YES count exceeds the present count
  function automatic outcome_e decide(input logic [BIN_W-1:0] present,
                                      input logic [BIN_W-1:0] yes);
    logic [BIN_W:0] twice;
    twice = {yes, 1'b0};
    if (twice > {1'b0, present}) return OUT_YES;
    if (twice < {1'b0, present}) return OUT_NO;
    return OUT_TIE;
  endfunction

endpackage

// File: rtl/vote_popcount.sv
module vote_popcount #(
  parameter int N  = 200,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
  end
endmodule

// File: rtl/vote_mode_fsm.sv
module vote_mode_fsm
  import vote_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  chair_sw,
  output mode_e mode_q,
  output logic  load_en
);
  mode_e mode_d;

  always_comb begin
    unique case (mode_q)
      MODE_IDLE:   mode_d = chair_sw ? MODE_IDLE   : MODE_VOTING;
      MODE_VOTING: mode_d = chair_sw ? MODE_RESULT : MODE_VOTING;
      MODE_RESULT: mode_d = chair_sw ? MODE_RESULT : MODE_VOTING;
      default:     mode_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_d;
  end

  // counts sample the seats only while voting is open
  assign load_en = (mode_q == MODE_VOTING);
endmodule

// File: rtl/vote_display.sv
module vote_display
  import vote_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [CW-1:0] present,
  input  logic [CW-1:0] yes,
  output logic          lamp_yes,
  output logic          lamp_tie,
  output logic          lamp_no,
  output logic [6:0]    seg_hund,
  output logic [6:0]    seg_tens,
  output logic [6:0]    seg_ones
);
  logic [4*DIGITS-1:0] bcd;
  logic [6:0]          seg_d [DIGITS];
  outcome_e            result;

  assign bcd    = to_bcd(BIN_W'(present));
  assign result = decide(BIN_W'(present), BIN_W'(yes));

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    if (d == DIGITS - 1) begin : g_lead
      assign seg_d[d] = (bcd[4*d +: 4] == 4'd0) ? 7'h00 : seg_of(bcd[4*d +: 4]);
    end else begin : g_plain
      assign seg_d[d] = seg_of(bcd[4*d +: 4]);
    end
  end

  assign seg_ones = seg_d[0];
  assign seg_tens = seg_d[1];
  assign seg_hund = seg_d[2];

  assign lamp_yes = (result == OUT_YES);
  assign lamp_no  = (result == OUT_NO);
  assign lamp_tie = (result == OUT_TIE);
endmodule

// File: rtl/vote_tally.sv
module vote_tally
  import vote_pkg::*;
#(
  parameter int NUM_SEATS = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SEATS-1:0] presence,
  input  logic [NUM_SEATS-1:0] vote,
  input  logic                 chair_sw,
  output logic                 lamp_yes,
  output logic                 lamp_tie,
  output logic                 lamp_no,
  output logic [6:0]           seg_hund,
  output logic [6:0]           seg_tens,
  output logic [6:0]           seg_ones
);
  localparam int CW = $clog2(NUM_SEATS + 1);

  logic [NUM_SEATS-1:0] yes_bits;
  logic [CW-1:0]        live_present, live_yes;
  logic [CW-1:0]        present_q, yes_q;
  logic                 load_en;
  mode_e                mode_q;

  // absent seats cannot contribute a YES
  assign yes_bits = presence & vote;

  vote_popcount #(.N(NUM_SEATS), .CW(CW)) u_cnt_present (
    .bits  (presence),
    .count (live_present)
  );

  vote_popcount #(.N(NUM_SEATS), .CW(CW)) u_cnt_yes (
    .bits  (yes_bits),
    .count (live_yes)
  );

  vote_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .chair_sw (chair_sw),
    .mode_q   (mode_q),
    .load_en  (load_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= '0;
      yes_q     <= '0;
    end else if (load_en) begin
      present_q <= live_present;
      yes_q     <= live_yes;
    end
  end

  vote_display #(.CW(CW)) u_disp (
    .present  (present_q),
    .yes      (yes_q),
    .lamp_yes (lamp_yes),
    .lamp_tie (lamp_tie),
    .lamp_no  (lamp_no),
    .seg_hund (seg_hund),
    .seg_tens (seg_tens),
    .seg_ones (seg_ones)
  );
endmodule

// File: rtl/vote_tally_chk.sv
module vote_tally_chk
  import vote_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chair_sw,
  input mode_e         mode_q,
  input logic [CW-1:0] present_q,
  input logic [CW-1:0] yes_q,
  input logic [CW-1:0] live_present,
  input logic          lamp_yes,
  input logic          lamp_tie,
  input logic          lamp_no,
  input logic [6:0]    seg_hund,
  input logic [6:0]    seg_tens,
  input logic [6:0]    seg_ones
);
  // R5
  one_lamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lamp_yes, lamp_tie, lamp_no}) == 1);

  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE) |-> (present_q == '0 && lamp_tie && seg_hund == 7'h00));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RESULT && chair_sw) |=>
      $stable({lamp_yes, lamp_tie, lamp_no, seg_hund, seg_tens, seg_ones}));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RESULT && !chair_sw) |=> (mode_q == MODE_VOTING));

  // R9
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && chair_sw) |=> (mode_q == MODE_IDLE));

  // R10
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_VOTING) |=> (present_q == $past(live_present)));

  // R6
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (present_q < CW'(100)) |-> (seg_hund == 7'h00));

  // R3
  yes_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yes_q <= present_q);
endmodule

bind vote_tally vote_tally_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chair_sw     (chair_sw),
  .mode_q       (mode_q),
  .present_q    (present_q),
  .yes_q        (yes_q),
  .live_present (live_present),
  .lamp_yes     (lamp_yes),
  .lamp_tie     (lamp_tie),
  .lamp_no      (lamp_no),
  .seg_hund     (seg_hund),
  .seg_tens     (seg_tens),
  .seg_ones     (seg_ones)
);

// File: tb/test_vote_tally.sv
`timescale 1ns/1ps
module test_vote_tally;
  localparam int SEATS = 200;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SEATS-1:0] presence = '0;
  logic [SEATS-1:0] vote = '0;
  logic             chair_sw = 1'b0;
  logic             lamp_yes, lamp_tie, lamp_no;
  logic [6:0]       seg_hund, seg_tens, seg_ones;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  vote_tally #(.NUM_SEATS(SEATS)) i_vote_tally (
    .clk (clk), .rst_n (rst_n), .presence (presence), .vote (vote),
    .chair_sw (chair_sw), .lamp_yes (lamp_yes), .lamp_tie (lamp_tie),
    .lamp_no (lamp_no), .seg_hund (seg_hund), .seg_tens (seg_tens),
    .seg_ones (seg_ones)
  );

  localparam logic [6:0] SEG [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                      7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  function automatic logic [SEATS-1:0] ones(input int n, input int sh);
    logic [SEATS-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = 1'b1;
    return r << sh;
  endfunction

  // {yes,tie,no,hund,tens,ones}
  function automatic logic [23:0] expect_of(input logic [SEATS-1:0] p,
                                            input logic [SEATS-1:0] v);
    int np = $countones(p);
    int ny = $countones(p & v);
    int nn = np - ny;
    logic [2:0] lamps = (ny > nn) ? 3'b100 : (ny < nn) ? 3'b001 : 3'b010;
    logic [6:0] h = (np / 100 == 0) ? 7'h00 : SEG[np / 100];
    return {lamps, h, SEG[(np / 10) % 10], SEG[np % 10]};
  endfunction

  function automatic logic [23:0] seen();
    return {lamp_yes, lamp_tie, lamp_no, seg_hund, seg_tens, seg_ones};
  endfunction

  task automatic check(input string req, input logic [23:0] exp_v);
    n_checks++;
    if (seen() !== exp_v) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, seen(), exp_v);
    end
  endtask

  task automatic apply(input logic [SEATS-1:0] p, input logic [SEATS-1:0] v,
                       input string req);
    @(negedge clk); presence = p; vote = v;
    @(negedge clk); check(req, expect_of(p, v));
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; chair_sw = 1'b0;
    presence = ones(SEATS, 0); vote = ones(SEATS, 0);
    @(negedge clk); check("R1 in reset", expect_of('0, '0));
    rst_n = 1'b1;
    @(negedge clk); check("R1 idle loads nothing", expect_of('0, '0));
    @(negedge clk); check("R10 first live", expect_of(presence, vote));
  endtask

  task automatic t_counts();
    apply(ones(5, 0), ones(3, 0), "R2 R4 five present yes");
    apply(ones(150, 20), ones(10, 20), "R2 R4 no wins");
    apply(ones(137, 0), ones(68, 0), "R4 one short no");
    apply(ones(12, 50), ones(6, 50), "R4 even tie");
    apply(ones(99, 0), ones(99, 0), "R6 99 blank hundreds");
    apply(ones(100, 0), '0, "R6 100 shown");
  endtask

  task automatic t_absent();
    apply('0, ones(SEATS, 0), "R3 R4 nobody present tie");
    apply(ones(4, 0), ones(2, 0) | ones(100, 100), "R3 absent yes ignored");
    apply(ones(4, 0), ones(100, 100), "R3 absent yes ignored no wins");
  endtask

  task automatic t_full();
    apply(ones(SEATS, 0), ones(SEATS, 0), "R6 full yes");
    apply(ones(SEATS, 0), ones(100, 0), "R6 R4 full tie");
  endtask

  task automatic t_latch();
    logic [23:0] held;
    @(negedge clk);
    presence = ones(30, 7); vote = ones(20, 7); chair_sw = 1'b1;
    held = expect_of(presence, vote);
    @(negedge clk); check("R7 capture", held);
    presence = ones(SEATS, 0); vote = '0;
    repeat (3) @(negedge clk);
    check("R7 hold after change", held);
    chair_sw = 1'b0;
    @(negedge clk); check("R8 still held", held);
    @(negedge clk); check("R8 live again", expect_of(presence, vote));
  endtask

  task automatic t_idle_chair();
    @(negedge clk); rst_n = 1'b0; chair_sw = 1'b1;
    presence = ones(50, 0); vote = ones(40, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 idle waits", expect_of('0, '0));
    chair_sw = 1'b0;
    @(negedge clk); check("R9 leaving idle", expect_of('0, '0));
    @(negedge clk); check("R9 live after idle", expect_of(presence, vote));
  endtask

  initial begin
    t_reset();
    t_counts();
    t_absent();
    t_full();
    t_latch();
    t_idle_chair();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #500000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule